// File: doc/BRIEF.md
# Fast-Page DRAM Controller with Byte Lanes

This controller turns a word-wide request port into the strobe sequences of an asynchronous x16 dynamic RAM. The RAM has multiplexed row and column address pins, one row strobe (RAS), a separate column strobe (CAS) for each byte lane, a write enable and an output enable. A request carries a 20-bit word address, 16 bits of write data, two byte enables and a direction bit. It is accepted by a valid/ready handshake. The controller activates the row, strobes the column and then leaves the row open. A later request to the same row needs only a new column strobe. A request to another row closes the page, waits the precharge time and activates the new row.

An interval timer requests refresh in CAS-before-RAS form. With the defaults it fires every 15.6 µs, which meets a 1024-row, 16 ms budget. A refresh that falls due while an access is in progress waits until that column access ends. The controller then closes the open row, precharges it and runs the refresh before it accepts any further request. Due refreshes that are not yet served are counted, and the count saturates at a set limit. All strobe timings are parameters given in clock cycles.

Top module: `pgdram_ctl`

## Requirements
- R1: The row is taken from address bits 19:10 and the column from bits 9:0. `dram_a` carries the row when RAS falls for an access and carries the column when CAS falls.
- R2: On a write, `dram_casl_n` (data bits 7:0) falls only when `req_be[0]` is 1, and `dram_cash_n` (data bits 15:8) falls only when `req_be[1]` is 1. A read drops both CAS strobes. Byte lanes that are not enabled keep their stored contents.
- R3: On a write, `dram_we_n` is low for at least one cycle before the first CAS falls. `dram_oe_n` stays high and `dram_dq_oe` is high while CAS is low.
- R4: On a read, `dram_oe_n` is low while CAS is low and `dram_dq_oe` is low. `dram_dq_in` is sampled T_RD cycles after CAS falls. The sampled word appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R5: A request to the row that is already open is served with no RAS rising edge. Back-to-back same-row requests cause no further row activation.
- R6: A request to a different row raises RAS and keeps it high for at least T_RP cycles before the new row is activated. Every column strobe comes at least T_RCD cycles after RAS falls.
- R7: A refresh drops both CAS strobes together, at least one cycle before RAS falls, with `dram_we_n` high.
- R8: Refresh cycles start every REF_CYC cycles, each within a small service latency. The count of due but unserved refreshes never exceeds MAX_DEFER.
- R9: While a refresh is due, `req_ready` is low. The open row is precharged for at least T_RP cycles before the refresh CAS strobes fall.
- R10: After reset, RAS, both CAS strobes, `dram_we_n` and `dram_oe_n` are high, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Word address, row in 19:10 and column in 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 for the low byte |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the RAM |
| dram_dq_oe | output | 1 | Data output enable for the DQ pads |
| dram_dq_in | input | 16 | Data returned from the RAM |

## Verification
The hardest case to reach is a refresh that falls due while a row is open and a request is in flight, including a page miss that is held during precharge. The order in which the row closes, the CAS-before-RAS refresh runs and the held row is activated can only be seen there. The bench shortens the refresh interval and sends a dense random stream of requests with small random gaps, so the timer expires in every controller state. A behavioural RAM model watches the strobe edges and checks the order, the spacing and the stored bytes at each event. Long idle stretches add refreshes that start from an idle open page.

// File: rtl/pgdram_pkg.sv
`timescale 1ns/1ps
package pgdram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_OPEN, ST_CSU, ST_COL, ST_PRE, ST_RCAS, ST_RRAS
  } seq_st_t;

  typedef enum logic {AS_ROW, AS_COL} asel_t;
endpackage

// File: rtl/pgdram_refresh.sv
`timescale 1ns/1ps
module pgdram_refresh #(
  parameter int REF_CYC   = 1560,
  parameter int MAX_DEFER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pend,
  output logic [$clog2(MAX_DEFER+1)-1:0] cnt_o
);
  localparam int TW = $clog2(REF_CYC + 1);
  localparam int CW = $clog2(MAX_DEFER + 1);
  localparam logic [TW-1:0] TICK_TOP = TW'(REF_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(MAX_DEFER);

  logic [TW-1:0] tick_q, tick_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          expire;

  assign expire = (tick_q == TICK_TOP);

  always_comb begin
    tick_d = expire ? '0 : tick_q + 1'b1;
    cnt_d  = cnt_q;
    if (expire && !take && cnt_q != CNT_TOP)
      cnt_d = cnt_q + 1'b1;
    else if (!expire && take && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      cnt_q  <= '0;
    end else begin
      tick_q <= tick_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pend  = (cnt_q != '0);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pgdram_amux.sv
`timescale 1ns/1ps
module pgdram_amux
  import pgdram_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  asel_t                  sel,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] a
);
  localparam int A_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  always_comb begin
    if (sel == AS_ROW) a = A_W'(addr[ROW_W+COL_W-1:COL_W]);
    else               a = A_W'(addr[COL_W-1:0]);
  end
endmodule

// File: rtl/pgdram_seq.sv
`timescale 1ns/1ps
module pgdram_seq
  import pgdram_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int LANE_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  parameter int T_RD   = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0]      req_wdata,
  input  logic [1:0]               req_be,
  input  logic                     ref_pend,
  output logic                     ref_take,
  output logic                     rsp_valid,
  output logic [2*LANE_W-1:0]      rsp_rdata,
  output asel_t                    asel,
  output logic [ROW_W+COL_W-1:0]   cur_addr,
  output logic                     ras_n,
  output logic                     casl_n,
  output logic                     cash_n,
  output logic                     we_n,
  output logic                     oe_n,
  output logic [2*LANE_W-1:0]      dq_out,
  output logic                     dq_oe,
  input  logic [2*LANE_W-1:0]      dq_in
);
  localparam int AW    = ROW_W + COL_W;
  localparam int DW    = 2 * LANE_W;
  localparam int T_REF = T_RCD + T_CAS;
  localparam int MAX_T = (T_REF > T_RP) ? T_REF : T_RP;
  localparam int CNT_W = $clog2(MAX_T + 1);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic [1:0]       be_q;
  logic             we_q, held_q, held_d, rsp_q, rsp_d;
  logic             acc, hit, rd_smp;

  assign req_ready = ((st_q == ST_IDLE) || (st_q == ST_OPEN)) && !ref_pend;
  assign acc       = req_valid && req_ready;
  assign hit       = (req_addr[AW-1:COL_W] == addr_q[AW-1:COL_W]);
  assign rd_smp    = (st_q == ST_COL) && !we_q && (cnt_q == CNT_W'(T_RD - 1));

  // next-state process
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    held_d = held_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) st_d = ST_RCAS;
        else if (acc) begin
          st_d  = ST_ACT;
          cnt_d = CNT_W'(T_RCD - 1);
        end
      end
      ST_ACT: begin
        if (cnt_q == '0) st_d = ST_CSU;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_CSU: begin
        st_d  = ST_COL;
        cnt_d = '0;
      end
      ST_COL: begin
        if (cnt_q == CNT_W'(T_CAS - 1)) st_d = ST_OPEN;
        else                            cnt_d = cnt_q + 1'b1;
      end
      ST_OPEN: begin
        if (ref_pend) begin
          st_d  = ST_PRE;
          cnt_d = CNT_W'(T_RP - 1);
        end else if (acc) begin
          if (hit) st_d = ST_CSU;
          else begin
            st_d   = ST_PRE;
            cnt_d  = CNT_W'(T_RP - 1);
            held_d = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (ref_pend) st_d = ST_RCAS;
        else if (held_q) begin
          st_d   = ST_ACT;
          cnt_d  = CNT_W'(T_RCD - 1);
          held_d = 1'b0;
        end else st_d = ST_IDLE;
      end
      ST_RCAS: begin
        st_d  = ST_RRAS;
        cnt_d = CNT_W'(T_REF - 1);
      end
      ST_RRAS: begin
        if (cnt_q == '0) begin
          st_d  = ST_PRE;
          cnt_d = CNT_W'(T_RP - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    rsp_d = rd_smp;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      held_q  <= 1'b0;
      rsp_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      held_q <= held_d;
      rsp_q  <= rsp_d;
      if (acc) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        we_q    <= req_we;
      end
      if (rd_smp) rdata_q <= dq_in;
    end
  end

  // strobe decode from the state register
  always_comb begin
    ras_n  = !((st_q == ST_ACT) || (st_q == ST_OPEN) || (st_q == ST_CSU) ||
               (st_q == ST_COL) || (st_q == ST_RRAS));
    casl_n = 1'b1;
    cash_n = 1'b1;
    if (st_q == ST_COL) begin
      casl_n = we_q ? !be_q[0] : 1'b0;
      cash_n = we_q ? !be_q[1] : 1'b0;
    end else if ((st_q == ST_RCAS) || (st_q == ST_RRAS)) begin
      casl_n = 1'b0;
      cash_n = 1'b0;
    end
    dq_oe = ((st_q == ST_CSU) || (st_q == ST_COL)) && we_q;
    we_n  = !dq_oe;
    oe_n  = !((st_q == ST_COL) && !we_q);
    asel  = ((st_q == ST_CSU) || (st_q == ST_COL)) ? AS_COL : AS_ROW;
  end

  assign ref_take  = (st_q == ST_RCAS);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign cur_addr  = addr_q;
  assign dq_out    = wdata_q;
endmodule

// File: rtl/pgdram_ctl.sv
`timescale 1ns/1ps
module pgdram_ctl
  import pgdram_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int LANE_W    = 8,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 2,
  parameter int T_RD      = 1,
  parameter int CLK_MHZ   = 100,
  parameter int REF_CYC   = (CLK_MHZ * 156) / 10,
  parameter int MAX_DEFER = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [2*LANE_W-1:0]    req_wdata,
  input  logic [1:0]             req_be,
  output logic                   rsp_valid,
  output logic [2*LANE_W-1:0]    rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_casl_n,
  output logic                   dram_cash_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [2*LANE_W-1:0]    dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [2*LANE_W-1:0]    dram_dq_in
);
  localparam int CW = $clog2(MAX_DEFER + 1);

  logic                   rst_meta_q, rst_sync_q;
  logic                   ref_pend, ref_take;
  logic [CW-1:0]          ref_cnt;
  asel_t                  asel;
  logic [ROW_W+COL_W-1:0] cur_addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pgdram_refresh #(.REF_CYC(REF_CYC), .MAX_DEFER(MAX_DEFER)) refresh_i (
    .clk(clk), .rst_n(rst_sync_q), .take(ref_take), .pend(ref_pend), .cnt_o(ref_cnt)
  );

  pgdram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RD(T_RD)
  ) seq_i (
    .clk(clk), .rst_n(rst_sync_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ref_pend(ref_pend), .ref_take(ref_take),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .asel(asel), .cur_addr(cur_addr),
    .ras_n(dram_ras_n), .casl_n(dram_casl_n), .cash_n(dram_cash_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n),
    .dq_out(dram_dq_out), .dq_oe(dram_dq_oe), .dq_in(dram_dq_in)
  );

  pgdram_amux #(.ROW_W(ROW_W), .COL_W(COL_W)) amux_i (
    .addr(cur_addr), .sel(asel), .a(dram_a)
  );
endmodule

// File: rtl/pgdram_ctl_chk.sv
`timescale 1ns/1ps
module pgdram_ctl_chk #(
  parameter int MAX_DEFER = 4,
  parameter int CW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          dram_ras_n,
  input logic          dram_casl_n,
  input logic          dram_cash_n,
  input logic          dram_we_n,
  input logic          dram_oe_n,
  input logic          dram_dq_oe,
  input logic [CW-1:0] ref_cnt
);
  // R7
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_casl_n) |->
      (!dram_cash_n && dram_we_n && $past(!dram_casl_n && !dram_cash_n)));

  // R3
  we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_casl_n) || $fell(dram_cash_n)) && !dram_we_n) |-> $past(!dram_we_n));

  // R3
  write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_we_n && (!dram_casl_n || !dram_cash_n)) |-> (dram_oe_n && dram_dq_oe));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> !dram_dq_oe);

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  defer_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= CW'(MAX_DEFER));

  // R9
  ref_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && !dram_casl_n) |-> !req_ready);
endmodule

bind pgdram_ctl pgdram_ctl_chk #(.MAX_DEFER(MAX_DEFER), .CW($clog2(MAX_DEFER + 1))) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe),
  .ref_cnt(ref_cnt)
);

// File: tb/pgdram_ctl_tb_top.sv
`timescale 1ns/1ps
module pgdram_ctl_tb_top;
  localparam int T_RCD   = 2;
  localparam int T_CAS   = 2;
  localparam int T_RP    = 2;
  localparam int T_RD    = 1;
  localparam int REF_CYC = 400;
  localparam int SLACK   = 30;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [9:0]  dram_a;
  logic        dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out, dram_dq_in;

  pgdram_ctl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RD(T_RD),
    .REF_CYC(REF_CYC), .MAX_DEFER(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural RAM model, reduced depth: 16 rows x 16 columns
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  logic [3:0]  row_lat, col_lat;
  logic [19:0] exp_addr;
  logic [1:0]  exp_be;
  bit          exp_we;
  bit          p_ras, p_casl, p_cash, p_we, seen_ref;
  int          ncyc, ras_rise_t, ras_fall_t, rd_fall_t, last_ref_t, act_cnt, ref_cnt;
  logic [15:0] exp_rd;

  assign dram_dq_in = !dram_oe_n ? mem[{row_lat, col_lat}] : 16'hDEAD;

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] be);
    merge = {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic [19:0] mk_addr(input int row, input int col);
    mk_addr = (20'(row) << 10) | 20'(col);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras <= 1'b1; p_casl <= 1'b1; p_cash <= 1'b1; p_we <= 1'b1;
      ncyc <= 0; ras_rise_t <= -100; ras_fall_t <= -100; rd_fall_t <= -100;
      last_ref_t <= 0; act_cnt <= 0; ref_cnt <= 0; seen_ref <= 1'b0;
    end else begin
      ncyc <= ncyc + 1;
      if (p_ras && !dram_ras_n) begin
        if (!dram_casl_n || !dram_cash_n) begin
          chk(p_casl == 0 && p_cash == 0 && !dram_casl_n && !dram_cash_n && dram_we_n,
              "R7 cas-before-ras order", {p_casl, p_cash}, 0);
          chk(ncyc - last_ref_t <= REF_CYC + SLACK, "R8 refresh gap max", ncyc - last_ref_t,
              REF_CYC + SLACK);
          if (seen_ref)
            chk(ncyc - last_ref_t >= REF_CYC - SLACK, "R8 refresh gap min",
                ncyc - last_ref_t, REF_CYC - SLACK);
          seen_ref <= 1'b1;
          last_ref_t <= ncyc;
          ref_cnt <= ref_cnt + 1;
        end else begin
          chk(dram_a == 10'(exp_addr[19:10]), "R1 row address", int'(dram_a),
              int'(exp_addr[19:10]));
          chk(ncyc - ras_rise_t >= T_RP, "R6 precharge time", ncyc - ras_rise_t, T_RP);
          row_lat <= dram_a[3:0];
          ras_fall_t <= ncyc;
          act_cnt <= act_cnt + 1;
        end
      end
      if (!p_ras && dram_ras_n) ras_rise_t <= ncyc;
      if (p_casl && p_cash && (!dram_casl_n || !dram_cash_n)) begin
        if (dram_ras_n) begin
          chk(ncyc - ras_rise_t >= T_RP, "R9 precharge before refresh", ncyc - ras_rise_t, T_RP);
          chk(!req_ready, "R9 ready low in refresh", int'(req_ready), 0);
        end else begin
          col_lat <= dram_a[3:0];
          chk(dram_a == exp_addr[9:0], "R1 column address", int'(dram_a), int'(exp_addr[9:0]));
          chk(ncyc - ras_fall_t >= T_RCD, "R6 ras-to-cas", ncyc - ras_fall_t, T_RCD);
          if (exp_we) begin
            chk(!p_we && dram_oe_n && dram_dq_oe, "R3 write strobes", {p_we, dram_oe_n}, 2'b01);
            chk({!dram_cash_n, !dram_casl_n} == exp_be, "R2 lane strobes",
                {!dram_cash_n, !dram_casl_n}, exp_be);
            mem[{row_lat, dram_a[3:0]}] <= merge(mem[{row_lat, dram_a[3:0]}], dram_dq_out,
                                                {!dram_cash_n, !dram_casl_n});
          end else begin
            chk(!dram_casl_n && !dram_cash_n && !dram_oe_n && !dram_dq_oe, "R4 read strobes",
                {dram_casl_n, dram_cash_n, dram_oe_n}, 0);
            rd_fall_t <= ncyc;
          end
        end
      end
      if (rsp_valid) begin
        chk(ncyc - rd_fall_t == T_RD, "R4 read latency", ncyc - rd_fall_t, T_RD);
        chk(rsp_rdata == exp_rd, "R2 R4 read data", int'(rsp_rdata), int'(exp_rd));
      end
      p_ras <= dram_ras_n; p_casl <= dram_casl_n; p_cash <= dram_cash_n; p_we <= dram_we_n;
    end
  end

  // one request; waits until the access has completed at the strobes
  task automatic do_req(input bit we, input int row, input int col,
                        input logic [15:0] data, input logic [1:0] be);
    logic [7:0] idx;
    bit got;
    idx = {4'(row), 4'(col)};
    @(negedge clk);
    exp_addr = mk_addr(row, col);
    exp_we = we;
    exp_be = we ? be : 2'b11;
    if (!we) exp_rd = shadow[idx];
    else shadow[idx] = merge(shadow[idx], data, be);
    req_valid = 1'b1; req_we = we; req_addr = mk_addr(row, col);
    req_wdata = data; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (we) begin
      while (!req_ready) @(negedge clk);
    end else begin
      got = 1'b0;
      while (!got) begin
        if (rsp_valid) got = 1'b1;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int a0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h0;
      shadow[i] = 16'h0;
    end
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = 2'b00;
    exp_addr = '0; exp_we = 1'b0; exp_be = 2'b11; exp_rd = '0;
    row_lat = '0; col_lat = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(dram_ras_n && dram_casl_n && dram_cash_n && dram_we_n && dram_oe_n,
        "R10 strobes idle", {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!rsp_valid && req_ready, "R10 handshake idle", {rsp_valid, req_ready}, 2'b01);

    // directed: lanes and page hits on row 3
    do_req(1'b1, 3, 1, 16'hA5C3, 2'b11);
    do_req(1'b1, 3, 1, 16'h0011, 2'b01);
    do_req(1'b0, 3, 1, 16'h0, 2'b11);
    chk(exp_rd == 16'hA511, "R2 lower-lane merge", int'(exp_rd), 16'hA511);
    do_req(1'b1, 3, 2, 16'h7E99, 2'b10);
    do_req(1'b0, 3, 2, 16'h0, 2'b11);
    chk(exp_rd == 16'h7E00, "R2 upper-lane merge", int'(exp_rd), 16'h7E00);
    @(negedge clk);
    chk(act_cnt == 1, "R5 page hits reuse row", act_cnt, 1);
    // page miss to row 7 and back to row 3
    do_req(1'b0, 7, 0, 16'h0, 2'b11);
    @(negedge clk);
    chk(act_cnt == 2, "R6 miss activates new row", act_cnt, 2);
    do_req(1'b0, 3, 1, 16'h0, 2'b11);
    @(negedge clk);
    chk(act_cnt == 3, "R6 return activates row", act_cnt, 3);

    // idle with page open: refreshes from open and idle states
    repeat (1300) @(negedge clk);
    chk(ref_cnt >= 2, "R8 refreshes while idle", ref_cnt, 2);

    // random traffic with small gaps
    for (int n = 0; n < 600; n++) begin
      bit w;
      logic [1:0] be;
      w = 1'($urandom % 2);
      be = w ? 2'(($urandom % 3) + 1) : 2'b11;
      do_req(w, int'($urandom % 4), int'($urandom % 16), 16'($urandom), be);
      repeat ($urandom % 4) @(negedge clk);
    end

    // final sweep of every stored word
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++)
        do_req(1'b0, r, c, 16'h0, 2'b11);

    a0 = ncyc;
    chk(ref_cnt >= a0 / REF_CYC - 1, "R8 refresh count", ref_cnt, a0 / REF_CYC - 1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule